// File: doc/BRIEF.md
# Dual-Channel Indirect-Register Serial Controller

This block is the register front end of a two-channel serial communications controller. A processor reaches it over a byte-wide bus. Each channel exposes a control port and a data port. Most of a channel's configuration is reached indirectly: a control-port write with the register pointer at zero loads the pointer, and the next control access uses that register and then sets the pointer back to zero. The same first write can also carry a command that clears a pending interrupt or selects the upper bank of eight registers.

On the line side each channel takes whole received bytes, each with a valid strobe, plus a break indication. It emits whole transmitted bytes with a one-cycle valid pulse. Each channel builds an interrupt request from its pending flags and its enable fields. The requests of both channels are merged onto one registered interrupt line. A write to control register 9 of either channel can return channel A, channel B or both to their reset state.

Top module: `duo_sercom`

## Requirements
- R1: Address bit 2 selects the channel (0 = A, 1 = B) and address bit 1 selects the port (0 = control, 1 = data). Address bit 0 is ignored. An access to one channel never changes the other, apart from the reset commands of R9.
- R2: A control write with the pointer at 0 loads the pointer with write-data bits 2:0. When bits 5:3 are 001, 8 is added to that number. The next control write stores its byte into the pointed register and returns the pointer to 0. The stored fields are: register 1 bit 0 (master interrupt enable), bit 1 (transmit interrupt enable) and bits 4:3 (receive interrupt mode); register 3 bit 0 (receive enable); register 5 bit 3 (transmit enable); register 15 bit 7 (break interrupt enable).
- R3: A control read returns the read register selected by the pointer and then returns the pointer to 0. Read register 0 holds break in bit 7, a constant 1 in bits 6 and 2, and character available in bit 0. Read register 1 reads 0x06. Every other read register reads 0x00.
- R4: When transmit enable is set, a data-port write is latched and appears on the channel's transmit data output. The transmit valid output is high for exactly the one cycle after the write, and the transmit-pending flag is set. When transmit enable is clear, the write produces no pulse and leaves the transmit-pending flag unchanged.
- R5: A received byte is accepted only when receive enable is 1 and character available is 0. Acceptance latches the byte, sets character available and sets receive-pending. A byte that arrives under any other condition is dropped. A data read returns the last latched byte and clears character available.
- R6: A break indication sets read register 0 bit 7. The bit stays set until the channel is reset.
- R7: A channel requests an interrupt when the master enable is set and one of the following holds: transmit interrupt enable is set and transmit is pending; the receive mode is 01 or 10 and receive is pending; break interrupt enable is set and break is set. The irq output is the OR of both requests, registered, so it follows a change one cycle after the flag or enable register updates.
- R8: With the pointer at 0, a control write whose bits 5:3 are 100 clears receive-pending, and one whose bits 5:3 are 101 clears transmit-pending.
- R9: When a control write is aimed at register 9, its bits 7:6 act as follows: 10 resets channel A, 01 resets channel B, 11 resets both, and 00 has no effect. The writing channel's pointer returns to 0 in every case.
- R10: After reset, or after a channel reset, the following hold: read register 0 reads 0x44; read register 1 reads 0x06; the pointer, the data latches and the pending flags are 0; receive, transmit, master and transmit interrupt enables are clear; the receive mode is 00; break interrupt enable is set; irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe; ignored while bus_wr is high |
| bus_addr | input | 3 | Bus address: bit 2 channel, bit 1 port |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Read data for the addressed port, valid in the cycle of the read |
| rxa_valid | input | 1 | Channel A received byte strobe |
| rxa_data | input | 8 | Channel A received byte |
| rxa_brk | input | 1 | Channel A break indication |
| rxb_valid | input | 1 | Channel B received byte strobe |
| rxb_data | input | 8 | Channel B received byte |
| rxb_brk | input | 1 | Channel B break indication |
| txa_valid | output | 1 | Channel A transmit byte pulse |
| txa_data | output | 8 | Channel A transmit byte |
| txb_valid | output | 1 | Channel B transmit byte pulse |
| txb_data | output | 8 | Channel B transmit byte |
| irq | output | 1 | Shared registered interrupt, active high |

## Verification
On every cycle the assertions check the following: the pointer returns to zero after a pointed write or a control read; no transmit pulse follows a data write while transmit is disabled; a held character is never overwritten; break stays set once raised; and irq follows any active channel request one cycle later. The pointer-high command, the contents of the read registers, the interrupt qualification by receive mode, the clear commands, and the cross-channel reset commands are shown only by the bench's directed scenarios. Those scenarios compare bus read data, transmit outputs and irq against values derived from the requirements.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

    localparam int N_CH     = 2;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int PTR_W    = 4;
    localparam int CH_BIT   = 2;
    localparam int PORT_BIT = 1;
    localparam int CMD_W    = 3;
    localparam int RCMD_W   = 2;

    localparam logic [PTR_W-1:0] REG_IE  = 4'd1;
    localparam logic [PTR_W-1:0] REG_RXC = 4'd3;
    localparam logic [PTR_W-1:0] REG_TXC = 4'd5;
    localparam logic [PTR_W-1:0] REG_RST = 4'd9;
    localparam logic [PTR_W-1:0] REG_EXT = 4'd15;

    localparam logic [BYTE_W-1:0] RR1_VAL = 8'h06;

    typedef enum logic [CMD_W-1:0] {
        CMD_NONE    = 3'b000,
        CMD_PT_HIGH = 3'b001,
        CMD_CLR_RX  = 3'b100,
        CMD_CLR_TX  = 3'b101
    } ctl_cmd_e;

    typedef struct packed {
        logic       ie_master;
        logic       ie_tx;
        logic [1:0] rx_mode;
        logic       rx_en;
        logic       tx_en;
        logic       brk_ie;
    } chan_cfg_t;

    localparam chan_cfg_t CFG_RST = '{
        ie_master: 1'b0, ie_tx: 1'b0, rx_mode: 2'b00,
        rx_en: 1'b0, tx_en: 1'b0, brk_ie: 1'b1
    };

    typedef struct packed {
        logic brk;
        logic avail;
        logic rx_pend;
        logic tx_pend;
    } chan_flags_t;

    localparam chan_flags_t FLAGS_RST = '{brk: 1'b0, avail: 1'b0, rx_pend: 1'b0, tx_pend: 1'b0};

    function automatic logic irq_eval(chan_cfg_t c, chan_flags_t f);
        logic rx_mode_ok;
        rx_mode_ok = (c.rx_mode == 2'b01) || (c.rx_mode == 2'b10);
        return c.ie_master &&
               ((c.ie_tx && f.tx_pend) ||
                (rx_mode_ok && f.rx_pend) ||
                (c.brk_ie && f.brk));
    endfunction

    function automatic logic [BYTE_W-1:0] status_pack(chan_flags_t f);
        return {f.brk, 1'b1, 3'b000, 1'b1, 1'b0, f.avail};
    endfunction

endpackage

// File: rtl/sercom_chan.sv
module sercom_chan
    import sercom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sreset,
    input  logic              wr_ctrl,
    input  logic              wr_data,
    input  logic              rd_ctrl,
    input  logic              rd_data,
    input  logic              sel_data,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_break,
    output logic [BYTE_W-1:0] rdata,
    output logic [RCMD_W-1:0] reset_cmd,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              irq_req
);

    logic [PTR_W-1:0]  ptr;
    chan_cfg_t         cfg;
    chan_flags_t       flg;
    logic [BYTE_W-1:0] rx_q;
    logic [BYTE_W-1:0] tx_q;
    logic              tx_v;
    logic [CMD_W-1:0]  cmd;
    logic              rx_take;
    logic [BYTE_W-1:0] rr_sel;

    assign cmd     = wdata[5:3];
    assign rx_take = rx_valid && cfg.rx_en && !flg.avail;

    always_comb begin
        reset_cmd = '0;
        if (wr_ctrl && (ptr == REG_RST)) begin
            reset_cmd = wdata[7:6];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || sreset) begin
            ptr  <= '0;
            cfg  <= CFG_RST;
            flg  <= FLAGS_RST;
            rx_q <= '0;
            tx_q <= '0;
            tx_v <= 1'b0;
        end else begin
            tx_v <= 1'b0;
            if (wr_ctrl) begin
                if (ptr == '0) begin
                    ptr <= {cmd == CMD_PT_HIGH, wdata[2:0]};
                    if (cmd == CMD_CLR_RX) flg.rx_pend <= 1'b0;
                    if (cmd == CMD_CLR_TX) flg.tx_pend <= 1'b0;
                end else begin
                    case (ptr)
                        REG_IE: begin
                            cfg.ie_master <= wdata[0];
                            cfg.ie_tx     <= wdata[1];
                            cfg.rx_mode   <= wdata[4:3];
                        end
                        REG_RXC: cfg.rx_en  <= wdata[0];
                        REG_TXC: cfg.tx_en  <= wdata[3];
                        REG_EXT: cfg.brk_ie <= wdata[7];
                        default: ;
                    endcase
                    ptr <= '0;
                end
            end else if (rd_ctrl) begin
                ptr <= '0;
            end
            if (wr_data && cfg.tx_en) begin
                tx_q        <= wdata;
                tx_v        <= 1'b1;
                flg.tx_pend <= 1'b1;
            end
            if (rd_data) flg.avail <= 1'b0;
            if (rx_take) begin
                rx_q        <= rx_data;
                flg.avail   <= 1'b1;
                flg.rx_pend <= 1'b1;
            end
            if (rx_break) flg.brk <= 1'b1;
        end
    end

    always_comb begin
        case (ptr)
            4'd0:    rr_sel = status_pack(flg);
            4'd1:    rr_sel = RR1_VAL;
            default: rr_sel = '0;
        endcase
    end

    assign rdata    = sel_data ? rx_q : rr_sel;
    assign tx_valid = tx_v;
    assign tx_data  = tx_q;
    assign irq_req  = irq_eval(cfg, flg);

    // R2: a pointed write always sends the pointer home
    a_r2_ptr_home_after_write: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && (ptr != '0)) |=> (ptr == '0));

    // R3: a control read sends the pointer home
    a_r3_ptr_home_after_read: assert property (@(posedge clk) disable iff (rst)
        (rd_ctrl && !wr_ctrl) |=> (ptr == '0));

    // R4: no transmit pulse while transmit is disabled
    a_r4_no_tx_disabled: assert property (@(posedge clk) disable iff (rst)
        (wr_data && !cfg.tx_en) |=> !tx_valid);

    // R5: a held character is never overwritten
    a_r5_rx_hold: assert property (@(posedge clk) disable iff (rst)
        (flg.avail && !sreset) |=> $stable(rx_q));

    // R6: break is sticky until a channel reset
    a_r6_break_sticky: assert property (@(posedge clk) disable iff (rst)
        (flg.brk && !sreset) |=> flg.brk);

endmodule

// File: rtl/sercom_irq.sv
module sercom_irq
    import sercom_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] req,
    output logic            irq
);

    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |req;
    end

    assign irq = irq_q;

    // R7: any active channel request shows on irq one cycle later
    a_r7_irq_follows_req: assert property (@(posedge clk) disable iff (rst)
        (|req) |=> irq);

    // R7: irq is low one cycle after no channel requests
    a_r7_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |=> !irq);

endmodule

// File: rtl/duo_sercom.sv
module duo_sercom
    import sercom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              rxa_valid,
    input  logic [BYTE_W-1:0] rxa_data,
    input  logic              rxa_brk,
    input  logic              rxb_valid,
    input  logic [BYTE_W-1:0] rxb_data,
    input  logic              rxb_brk,
    output logic              txa_valid,
    output logic [BYTE_W-1:0] txa_data,
    output logic              txb_valid,
    output logic [BYTE_W-1:0] txb_data,
    output logic              irq
);

    logic              ch_idx;
    logic              port_data;
    logic              rd_ok;
    logic [N_CH-1:0]   wr_ctrl, wr_data, rd_ctrl, rd_data, sreset, req;
    logic [N_CH-1:0]   rx_valid, rx_brk, tx_valid;
    logic [BYTE_W-1:0] rx_data  [N_CH];
    logic [BYTE_W-1:0] tx_data  [N_CH];
    logic [BYTE_W-1:0] ch_rdata [N_CH];
    logic [RCMD_W-1:0] rcmd     [N_CH];

    assign ch_idx    = bus_addr[CH_BIT];
    assign port_data = bus_addr[PORT_BIT];
    assign rd_ok     = bus_rd && !bus_wr;

    assign rx_valid = {rxb_valid, rxa_valid};
    assign rx_brk   = {rxb_brk, rxa_brk};
    assign rx_data[0] = rxa_data;
    assign rx_data[1] = rxb_data;

    genvar c;
    generate
        for (c = 0; c < N_CH; c++) begin : g_ch
            logic sel;
            assign sel        = (ch_idx == c[0]);
            assign wr_ctrl[c] = bus_wr && sel && !port_data;
            assign wr_data[c] = bus_wr && sel &&  port_data;
            assign rd_ctrl[c] = rd_ok  && sel && !port_data;
            assign rd_data[c] = rd_ok  && sel &&  port_data;
            // command bit 7 targets channel A, bit 6 targets channel B
            assign sreset[c]  = rcmd[0][RCMD_W-1-c] | rcmd[1][RCMD_W-1-c];

            sercom_chan u_chan (
                .clk       (clk),
                .rst       (rst),
                .sreset    (sreset[c]),
                .wr_ctrl   (wr_ctrl[c]),
                .wr_data   (wr_data[c]),
                .rd_ctrl   (rd_ctrl[c]),
                .rd_data   (rd_data[c]),
                .sel_data  (port_data),
                .wdata     (bus_wdata),
                .rx_valid  (rx_valid[c]),
                .rx_data   (rx_data[c]),
                .rx_break  (rx_brk[c]),
                .rdata     (ch_rdata[c]),
                .reset_cmd (rcmd[c]),
                .tx_valid  (tx_valid[c]),
                .tx_data   (tx_data[c]),
                .irq_req   (req[c])
            );
        end
    endgenerate

    assign bus_rdata = ch_rdata[ch_idx];
    assign txa_valid = tx_valid[0];
    assign txb_valid = tx_valid[1];
    assign txa_data  = tx_data[0];
    assign txb_data  = tx_data[1];

    sercom_irq u_irq (
        .clk (clk),
        .rst (rst),
        .req (req),
        .irq (irq)
    );

    // R1: a write never touches both channels at once
    a_r1_single_channel: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_ctrl | wr_data));

endmodule

// File: tb/duo_sercom_bench.sv
`timescale 1ns/1ps
module duo_sercom_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rxa_valid = 1'b0, rxa_brk = 1'b0, rxb_valid = 1'b0, rxb_brk = 1'b0;
    logic [7:0] rxa_data = '0, rxb_data = '0;
    logic       txa_valid, txb_valid, irq;
    logic [7:0] txa_data, txb_data;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [2:0] A_CTL = 3'd0, A_DAT = 3'd2, B_CTL = 3'd4, B_DAT = 3'd6;

    always #2.5 clk = ~clk;

    duo_sercom u_duo_sercom (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxa_valid(rxa_valid), .rxa_data(rxa_data), .rxa_brk(rxa_brk),
        .rxb_valid(rxb_valid), .rxb_data(rxb_data), .rxb_brk(rxb_brk),
        .txa_valid(txa_valid), .txa_data(txa_data),
        .txb_valid(txb_valid), .txb_data(txb_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bw(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic br(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic setreg(input logic [2:0] ctl, input logic [3:0] r, input logic [7:0] v);
        bw(ctl, {2'b00, (r[3] ? 3'b001 : 3'b000), r[2:0]});
        bw(ctl, v);
    endtask

    task automatic rx_a(input logic [7:0] d);
        rxa_data = d; rxa_valid = 1'b1;
        @(negedge clk);
        rxa_valid = 1'b0;
    endtask

    task automatic do_reset;
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        do_reset();
        chk("R10 irq low", {7'd0, irq}, 8'h00);
        br(A_CTL, d); chk("R10 A rr0", d, 8'h44);
        bw(A_CTL, 8'h01); br(A_CTL, d); chk("R10 A rr1", d, 8'h06);
        br(B_CTL, d); chk("R10 B rr0", d, 8'h44);
        br(A_DAT, d); chk("R10 A rx latch", d, 8'h00);
        bw(A_DAT, 8'h5A); chk("R10 tx disabled", {7'd0, txa_valid}, 8'h00);
    endtask

    task automatic t_read_regs;
        logic [7:0] d;
        do_reset();
        bw(A_CTL, 8'h01); br(A_CTL, d); chk("R3 rr1", d, 8'h06);
        br(A_CTL, d); chk("R3 pointer home rr0", d, 8'h44);
        bw(A_CTL, 8'h02); br(A_CTL, d); chk("R3 rr2 zero", d, 8'h00);
        bw(A_CTL, 8'h0D); br(A_CTL, d); chk("R3 rr13 zero", d, 8'h00);
        bw(3'b001, 8'h01); br(3'b001, d); chk("R1 addr bit0 ignored", d, 8'h06);
    endtask

    task automatic t_pointer;
        do_reset();
        setreg(A_CTL, 4'd1, 8'h01);
        setreg(A_CTL, 4'd7, 8'h00);
        rxa_brk = 1'b1; @(negedge clk); rxa_brk = 1'b0;
        idle(1);
        chk("R2 low pointer leaves break enable", {7'd0, irq}, 8'h01);
        do_reset();
        setreg(A_CTL, 4'd1, 8'h01);
        bw(A_CTL, 8'h0F); bw(A_CTL, 8'h00);
        rxa_brk = 1'b1; @(negedge clk); rxa_brk = 1'b0;
        idle(1);
        chk("R2 point high reaches reg15", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_tx;
        do_reset();
        bw(A_DAT, 8'h11);
        chk("R4 no pulse disabled", {7'd0, txa_valid}, 8'h00);
        setreg(A_CTL, 4'd5, 8'h08);
        bw(A_DAT, 8'hC3);
        chk("R4 pulse", {7'd0, txa_valid}, 8'h01);
        chk("R4 data", txa_data, 8'hC3);
        idle(1);
        chk("R4 pulse one cycle", {7'd0, txa_valid}, 8'h00);
        chk("R1 B untouched", {7'd0, txb_valid}, 8'h00);
        bw(B_DAT, 8'h77);
        chk("R1 B disabled no pulse", {7'd0, txb_valid}, 8'h00);
    endtask

    task automatic t_rx;
        logic [7:0] d;
        do_reset();
        rx_a(8'h99);
        br(A_CTL, d); chk("R5 rx disabled drops", d, 8'h44);
        setreg(A_CTL, 4'd3, 8'h01);
        rx_a(8'h11);
        br(A_CTL, d); chk("R5 avail set", d, 8'h45);
        rx_a(8'h22);
        br(A_DAT, d); chk("R5 held byte kept", d, 8'h11);
        br(A_CTL, d); chk("R5 data read clears avail", d, 8'h44);
        setreg(A_CTL, 4'd3, 8'h00);
        rx_a(8'h33);
        br(A_DAT, d); chk("R5 last latched byte", d, 8'h11);
        br(B_CTL, d); chk("R1 B rr0 unaffected", d, 8'h44);
    endtask

    task automatic t_break;
        logic [7:0] d;
        do_reset();
        rxa_brk = 1'b1; @(negedge clk); rxa_brk = 1'b0;
        br(A_CTL, d); chk("R6 break bit", d, 8'hC4);
        idle(3);
        br(A_CTL, d); chk("R6 break sticky", d, 8'hC4);
    endtask

    task automatic t_irq;
        logic [7:0] d;
        do_reset();
        setreg(A_CTL, 4'd3, 8'h01);
        setreg(A_CTL, 4'd1, 8'h09);
        rx_a(8'h41);
        chk("R7 irq lags one cycle", {7'd0, irq}, 8'h00);
        idle(1);
        chk("R7 rx irq mode01", {7'd0, irq}, 8'h01);
        br(A_DAT, d);
        idle(1);
        chk("R7 data read keeps pending", {7'd0, irq}, 8'h01);
        bw(A_CTL, 8'h20); idle(1);
        chk("R8 clear rx pending", {7'd0, irq}, 8'h00);
        setreg(A_CTL, 4'd1, 8'h19);
        rx_a(8'h42); idle(1);
        chk("R7 mode11 no irq", {7'd0, irq}, 8'h00);
        setreg(A_CTL, 4'd1, 8'h11); idle(1);
        chk("R7 mode10 irq", {7'd0, irq}, 8'h01);
        setreg(A_CTL, 4'd1, 8'h10); idle(1);
        chk("R7 master off", {7'd0, irq}, 8'h00);
        do_reset();
        setreg(B_CTL, 4'd5, 8'h08);
        setreg(B_CTL, 4'd1, 8'h03);
        bw(B_DAT, 8'h10); idle(1);
        chk("R7 tx irq B", {7'd0, irq}, 8'h01);
        bw(B_CTL, 8'h20); idle(1);
        chk("R8 rx clear keeps tx", {7'd0, irq}, 8'h01);
        bw(B_CTL, 8'h28); idle(1);
        chk("R8 clear tx pending", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_chan_reset;
        logic [7:0] d;
        do_reset();
        setreg(A_CTL, 4'd3, 8'h01);
        setreg(A_CTL, 4'd5, 8'h08);
        rx_a(8'h5C);
        setreg(B_CTL, 4'd9, 8'h00);
        br(A_CTL, d); chk("R9 cmd00 no effect", d, 8'h45);
        bw(B_CTL, 8'h01); br(B_CTL, d); chk("R9 writer pointer home", d, 8'h06);
        setreg(B_CTL, 4'd9, 8'h80);
        br(A_CTL, d); chk("R9 A reset rr0", d, 8'h44);
        br(A_DAT, d); chk("R9 A latch cleared", d, 8'h00);
        bw(A_DAT, 8'h66); chk("R9 A tx disabled", {7'd0, txa_valid}, 8'h00);
        br(B_CTL, d); chk("R9 B pointer home", d, 8'h44);
        setreg(A_CTL, 4'd3, 8'h01);
        rx_a(8'h12);
        setreg(A_CTL, 4'd9, 8'h40);
        br(A_CTL, d); chk("R9 cmd01 spares A", d, 8'h45);
        rxb_brk = 1'b1; @(negedge clk); rxb_brk = 1'b0;
        setreg(A_CTL, 4'd9, 8'hC0);
        br(A_CTL, d); chk("R9 both reset A", d, 8'h44);
        br(B_CTL, d); chk("R9 both reset B", d, 8'h44);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_read_regs();
        t_pointer();
        t_tx();
        t_rx();
        t_break();
        t_irq();
        t_chan_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule